// File: doc/BRIEF.md
# Wait-State Synchronous Bus Master

This block is a bus master for clocked read and write cycles against slaves of mixed speed. A local command port presents an address, write data, a direction flag and a valid bit. While the master is idle it accepts the command. On that rising edge it launches the address, the write data and a one-hot chip-select onto the bus. The chip-select comes from a range compare of the address.

Half a clock later, on the falling edge, the master raises the read or write strobe, so the address has a half period to settle first. A fast slave leaves its wait line low, and the transfer ends on the next rising edge as a plain synchronous cycle. A slow slave holds the wait line high. While it does, the master freezes every bus output. When the line drops, the master completes the cycle on the next rising edge with the usual edge timing.

A cycle counter bounds how long a stuck slave can hold the bus. An address that falls outside every slave region ends the cycle at once and reports an error. No strobe is driven for it.

Top module: `wsbus_master`

## Requirements
- R1: After reset the master is idle: `cmd_ready`=1, `rsp_done`=0, `rsp_err`=0, both strobes are 0 and `bus_cs` is all zero.
- R2: A command is taken only on a rising edge where `cmd_ready`=1 and `cmd_valid`=1. A `cmd_valid` presented while a cycle is in progress is ignored: `bus_addr` keeps the running cycle's address and no extra completion occurs.
- R3: On the accepting edge, `bus_addr` takes `cmd_addr`. `bus_cs` becomes one-hot, with bit i set when the upper address bits `addr[ADDR_W-1:SPAN_W]` equal i, for i < NUM_SEL. If no region matches, `bus_cs` stays all zero.
- R4: The read strobe (reads) or write strobe (writes) is 0 right after the accepting edge. It goes to 1 at the following falling edge when the address is mapped, and stays 1 until the cycle ends.
- R5: With `bus_wait` low at the first rising edge after acceptance, the cycle completes on that edge: `rsp_done`=1 and `cmd_ready`=1.
- R6: Each rising edge that samples `bus_wait`=1 delays completion by one clock. While the cycle is stretched, `bus_addr`, `bus_cs`, `bus_wdata` and the strobe hold their values.
- R7: A read that completes without error returns on `rsp_rdata` the value of `bus_rdata` at the completion edge. Writes and errored cycles return 0.
- R8: If `bus_wait` is sampled high on MAX_WAIT consecutive edges, the cycle ends on the MAX_WAIT-th of those edges with `rsp_done`=1 and `rsp_err`=1.
- R9: An unmapped address drives no strobe. It ends on the first rising edge after acceptance with `rsp_err`=1, whatever `bus_wait` does.
- R10: `rsp_done` is high for exactly one clock per accepted command. `rsp_err` is high only together with `rsp_done`. Both strobes and `bus_cs` are 0 whenever the master is idle.
- R11: A write launches `cmd_wdata` on `bus_wdata` at the accepting edge and completes with `rsp_err`=0 under the same wait rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Master idle and able to take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read result, valid with `rsp_done` |
| rsp_err | output | 1 | Timeout or unmapped address, valid with `rsp_done` |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rd | output | 1 | Read strobe, raised on a falling edge |
| bus_wr | output | 1 | Write strobe, raised on a falling edge |
| bus_cs | output | NUM_SEL | One-hot slave select |
| bus_wait | input | 1 | Slave stretch request |
| bus_rdata | input | DATA_W | Slave read data |

## Verification
The bench builds the master with a 6-bit address, three 16-byte regions and MAX_WAIT=4. With these values every address can be swept. Both the mapped range and the unmapped range of 48 to 63 are covered.

Each address is given a wait length from 0 to 5. This covers every stretch the counter allows and also timeouts one and two edges past the limit. A second command is pushed in during each busy cycle to show that it is refused.

// File: rtl/wsbus_pkg.sv
package wsbus_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } wsbus_state_e;

  // Region number of an address: the bits above the region span.
  function automatic int unsigned region_of(input int unsigned addr,
                                            input int unsigned span_w);
    return addr >> span_w;
  endfunction

  // True when the wait counter has reached its last allowed sample.
  function automatic logic wait_at_limit(input int unsigned cnt,
                                         input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

endpackage

// File: rtl/wsbus_decode.sv
module wsbus_decode #(
  parameter int ADDR_W  = 6,
  parameter int SPAN_W  = 4,
  parameter int NUM_SEL = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_SEL-1:0] cs,
  output logic               hit
);
  import wsbus_pkg::*;

  localparam int IDX_W = ADDR_W - SPAN_W;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:SPAN_W];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_region
    assign cs[i] = (idx == IDX_W'(i));
  end

  assign hit = |cs;

endmodule

// File: rtl/wsbus_wait_ctr.sv
module wsbus_wait_ctr #(
  parameter int MAX_WAIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic expire
);
  import wsbus_pkg::*;

  localparam int CNT_W = $clog2(MAX_WAIT + 1);

  logic [CNT_W-1:0] cnt;

  assign expire = count_en && wait_at_limit(int'(cnt), MAX_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (count_en && !expire) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wsbus_strobe.sv
module wsbus_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic write,
  output logic rd_q,
  output logic wr_q
);

  // Strobes change on the falling edge, half a clock after the address.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= active && !write;
      wr_q <= active && write;
    end
  end

endmodule

// File: rtl/wsbus_master.sv
module wsbus_master #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int SPAN_W   = 4,
  parameter int NUM_SEL  = 3,
  parameter int MAX_WAIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_write,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  output logic               rsp_done,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  output logic               bus_rd,
  output logic               bus_wr,
  output logic [NUM_SEL-1:0] bus_cs,
  input  logic               bus_wait,
  input  logic [DATA_W-1:0]  bus_rdata
);
  import wsbus_pkg::*;

  wsbus_state_e state;

  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               write_q;
  logic               hit_q;
  logic [NUM_SEL-1:0] cs_q;

  logic [NUM_SEL-1:0] cs_dec;
  logic               hit_dec;
  logic               rd_q, wr_q;
  logic               expire;

  // Named internal events
  logic accept;
  logic sample_edge;
  logic strobe_on;
  logic finish_ok;
  logic finish_unmapped;
  logic timeout_hit;
  logic finish;

  wsbus_decode #(
    .ADDR_W (ADDR_W),
    .SPAN_W (SPAN_W),
    .NUM_SEL(NUM_SEL)
  ) u_dec (
    .addr(cmd_addr),
    .cs  (cs_dec),
    .hit (hit_dec)
  );

  wsbus_wait_ctr #(
    .MAX_WAIT(MAX_WAIT)
  ) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .count_en(sample_edge && hit_q && bus_wait),
    .expire  (expire)
  );

  wsbus_strobe u_stb (
    .clk   (clk),
    .rst_n (rst_n),
    .active((state == ST_ACCESS) && hit_q),
    .write (write_q),
    .rd_q  (rd_q),
    .wr_q  (wr_q)
  );

  assign accept          = (state == ST_IDLE) && cmd_valid;
  assign sample_edge     = (state == ST_ACCESS);
  assign strobe_on       = bus_rd || bus_wr;
  assign finish_ok       = sample_edge && hit_q && strobe_on && !bus_wait;
  assign finish_unmapped = sample_edge && !hit_q;
  assign timeout_hit     = sample_edge && hit_q && bus_wait && expire;
  assign finish          = finish_ok || finish_unmapped || timeout_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
      hit_q     <= 1'b0;
      cs_q      <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      if (accept) begin
        state   <= ST_ACCESS;
        addr_q  <= cmd_addr;
        wdata_q <= cmd_wdata;
        write_q <= cmd_write;
        hit_q   <= hit_dec;
        cs_q    <= cs_dec;
      end else if (finish) begin
        state     <= ST_IDLE;
        cs_q      <= '0;
        rsp_done  <= 1'b1;
        rsp_err   <= finish_unmapped || timeout_hit;
        rsp_rdata <= (finish_ok && !write_q) ? bus_rdata : '0;
      end
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_cs    = cs_q;
  assign bus_rd    = rd_q && sample_edge;
  assign bus_wr    = wr_q && sample_edge;

endmodule

// File: rtl/wsbus_master_chk.sv
module wsbus_master_chk #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int NUM_SEL  = 3,
  parameter int MAX_WAIT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_ready,
  input logic               rsp_done,
  input logic               rsp_err,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [NUM_SEL-1:0] bus_cs,
  input logic               bus_wait,
  input logic               timeout_hit,
  input logic               finish_unmapped
);

  localparam int BC_W = $clog2(MAX_WAIT + 2) + 1;
  logic [BC_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_cnt <= '0;
    else if (cmd_ready)  busy_cnt <= '0;
    else                 busy_cnt <= busy_cnt + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!bus_rd && !bus_wr && bus_cs == '0)); // R10

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_cs)); // R3

  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> (bus_cs != '0)); // R9

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && bus_wait && (bus_rd || bus_wr) && !timeout_hit) |=>
      ($stable(bus_addr) && $stable(bus_cs) && $stable(bus_wdata) &&
       $stable(bus_rd) && $stable(bus_wr))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done); // R10

  AST_TIMEOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> (rsp_done && rsp_err)); // R8

  AST_UNMAPPED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    finish_unmapped |=> (rsp_done && rsp_err)); // R9

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BC_W'(MAX_WAIT)); // R8

endmodule

bind wsbus_master wsbus_master_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NUM_SEL (NUM_SEL),
  .MAX_WAIT(MAX_WAIT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_ready      (cmd_ready),
  .rsp_done       (rsp_done),
  .rsp_err        (rsp_err),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .bus_rd         (bus_rd),
  .bus_wr         (bus_wr),
  .bus_cs         (bus_cs),
  .bus_wait       (bus_wait),
  .timeout_hit    (timeout_hit),
  .finish_unmapped(finish_unmapped)
);

// File: tb/sim_wsbus_master.sv
module sim_wsbus_master;

  localparam int AW = 6, DW = 8, SW = 4, NS = 3, MW = 4;
  localparam int MAPPED_TOP = NS << SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_rd, bus_wr;
  logic [NS-1:0] bus_cs;
  logic          bus_wait = 1'b0;
  logic [DW-1:0] bus_rdata;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] slave_val(input logic [AW-1:0] a);
    return DW'((int'(a) * 37 + 11) % 256);
  endfunction

  assign bus_rdata = ((|bus_cs) && bus_rd) ? slave_val(bus_addr) : '0;

  wsbus_master #(
    .ADDR_W(AW), .DATA_W(DW), .SPAN_W(SW), .NUM_SEL(NS), .MAX_WAIT(MW)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_cs(bus_cs), .bus_wait(bus_wait),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(input bit wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input int k);
    bit          mapped = int'(a) < MAPPED_TOP;
    int          endn   = !mapped ? 1 : ((k >= MW) ? MW : k + 1);
    bit          err_e  = !mapped || (k >= MW);
    logic [NS-1:0] cs_e = mapped ? NS'(1 << (int'(a) >> SW)) : '0;
    logic [DW-1:0] rd_e = (!wr && !err_e) ? slave_val(a) : '0;

    @(negedge clk);
    check(cmd_ready == 1'b1, "R2", "ready before command", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd;
    bus_wait  = (k >= 1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    check(bus_addr == a, "R3", "launched address", bus_addr, a);
    check(bus_cs == cs_e, "R3", "chip select", bus_cs, cs_e);
    check(!bus_rd && !bus_wr, "R4", "strobe before falling edge",
          {bus_rd, bus_wr}, 0);
    if (wr) check(bus_wdata == wd, "R11", "write data", bus_wdata, wd);

    for (int n = 1; n <= endn; n++) begin
      @(negedge clk); #1;
      check(bus_rd == (mapped && !wr), mapped ? "R4" : "R9", "read strobe",
            bus_rd, mapped && !wr);
      check(bus_wr == (mapped && wr), mapped ? "R4" : "R9", "write strobe",
            bus_wr, mapped && wr);
      bus_wait = (n <= k);
      if (n == 1) begin
        cmd_valid = 1'b1; cmd_addr = a ^ 6'h21; cmd_write = ~wr;
      end
      @(posedge clk); #1;
      cmd_valid = 1'b0;
      if (n < endn) begin
        check(!rsp_done, "R6", "done while stretched", rsp_done, 0);
        check(bus_addr == a && bus_cs == cs_e, "R6", "held address/cs",
              bus_addr, a);
        check(bus_addr == a, "R2", "busy command ignored", bus_addr, a);
      end else begin
        check(rsp_done == 1'b1, (k == 0 || !mapped) ? "R5" : "R6",
              "done at expected edge", rsp_done, 1);
        check(rsp_err == err_e, (!mapped) ? "R9" : ((k >= MW) ? "R8" : "R11"),
              "error flag", rsp_err, err_e);
        check(rsp_rdata == rd_e, "R7", "returned data", rsp_rdata, rd_e);
        check(cmd_ready == 1'b1, "R5", "ready with done", cmd_ready, 1);
        check(bus_addr == a, "R2", "busy command ignored", bus_addr, a);
      end
    end
    bus_wait = 1'b0;
    @(posedge clk); #1;
    check(!rsp_done && !rsp_err, "R10", "done one clock only", rsp_done, 0);
    check(!bus_rd && !bus_wr && bus_cs == '0, "R10", "quiet when idle",
          {bus_rd, bus_wr, bus_cs}, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(cmd_ready && !rsp_done && !rsp_err, "R1", "reset handshake",
          {cmd_ready, rsp_done, rsp_err}, 3'b100);
    check(!bus_rd && !bus_wr && bus_cs == '0, "R1", "reset bus",
          {bus_rd, bus_wr, bus_cs}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(cmd_ready == 1'b1, "R1", "idle after reset", cmd_ready, 1);

    for (int a = 0; a < (1 << AW); a++)
      run_cycle(1'b0, AW'(a), '0, a % 6);
    for (int a = 0; a < (1 << AW); a += 3)
      run_cycle(1'b1, AW'(a), DW'(a * 5 + 1), (a / 3) % 6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule